// File: doc/BRIEF.md
# Four-Phase Overlapped Instruction Sequencer

This block is the control core of a small microcontroller-style processor. It divides the incoming clock into four phase slots per instruction cycle and runs two stages in parallel. While one instruction word executes from the instruction register, the next word is being read from program memory. The block drives the program-memory address and captures the returned word. It also issues the operand-read and result-write strobes for data memory, and it keeps a small hardware stack of return addresses.

A simple decoder outside the block looks at the instruction word and raises jump, subroutine-entry or subroutine-exit requests, with a destination address. The sequencer samples these requests in the third phase. When a request is accepted, the word already being read is from the wrong address and must be discarded. The sequencer puts a no-operation word in its place for the next cycle, so any change of flow takes two instruction cycles. Every other instruction takes one.

Top module: `quad_fetch_seq`

## Requirements
- R1: `qPhase` is one-hot, with bit 0 for phase Q1 through bit 3 for phase Q4. It steps Q1→Q2→Q3→Q4→Q1 on every clock, and reset puts it in Q1.
- R2: While reset is active, and for the whole first instruction cycle after reset, `progAddr` is 0, `irWord` is the no-operation word (all zeros) and `execNop` is 1.
- R3: `progAddr` changes only at the start of Q1. With no accepted flow change it goes up by one per instruction cycle.
- R4: The `progData` present during Q4 is latched at the end of Q4. It appears on `irWord` from Q1 of the next cycle, unless that cycle is a forced no-operation.
- R5: `dataRdStb` is high only in Q2 and `dataWrStb` only in Q4, and only in cycles where `execNop` is 0. Both are low in Q1 and Q3.
- R6: A flow request sampled in Q3 is accepted when `execNop` is 0. In the next cycle `progAddr` is the new address, `irWord` is all zeros and `execNop` is 1. In the cycle after that, `progAddr` is the new address plus one.
- R7: An accepted subroutine entry (`isCall`) saves the `progAddr` of its own execute cycle, which is the address after the call, on the return stack. It then jumps to `flowTarget`.
- R8: An accepted subroutine exit (`isReturn`) takes the most recently saved address off the stack and continues fetching from it, taking two cycles.
- R9: If more than one request is raised at once, exit wins over entry and entry wins over jump. An entry raised together with a jump still saves its return address.
- R10: Flow requests are ignored in any cycle with `execNop` at 1, so two no-operation cycles never follow each other.
- R11: The return stack holds 8 entries and wraps around. A ninth entry overwrites the oldest with no error indication, so after nine entries and eight exits, a ninth exit returns the most recently saved address again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, four per instruction cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| progAddr | output | 11 | Program-memory address being fetched this cycle |
| progData | input | 14 | Word returned by program memory |
| irWord | output | 14 | Instruction word executing this cycle |
| isBranch | input | 1 | Decoder: jump to `flowTarget` |
| isCall | input | 1 | Decoder: subroutine entry at `flowTarget` |
| isReturn | input | 1 | Decoder: subroutine exit |
| flowTarget | input | 11 | Destination address for jump or entry |
| qPhase | output | 4 | One-hot phase strobes Q1..Q4 |
| dataRdStb | output | 1 | Data-memory operand read strobe |
| dataWrStb | output | 1 | Data-memory result write strobe |
| execNop | output | 1 | Current cycle executes a forced no-operation |

## Verification
Some properties are checked on every clock. These are the one-hot rotation of the phases, that the address moves only at a cycle boundary, that each data strobe appears only in its own phase, and that an accepted flow request leads to exactly one no-operation cycle. That no-operation cycle must itself advance the address sequentially and never chain into a second one. The stimulus scenarios are the only way to show the actual destination addresses, which return address the stack gives back (including wrap-around after nine saves), the priority among simultaneous requests, and which word reaches the instruction register.

// File: rtl/seq_pkg.sv
package seq_pkg;

  // Control strobes handed from the sequencer control to the datapath.
  typedef struct packed {
    logic advance;     // end of Q4: move fetch address, latch instruction
    logic forceNop;    // replace the latched word with the no-operation word
    logic loadTarget;  // end of Q3: next PC comes from the target input
    logic push;        // end of Q3: save the address after the current one
    logic pop;         // end of Q3: next PC comes from the return stack
  } seqStrobe_t;

endpackage

// File: rtl/seq_phase_gen.sv
module seq_phase_gen #(
  parameter int NUM_PHASES = 4,
  localparam int PW = $clog2(NUM_PHASES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  output logic [NUM_PHASES-1:0] qPhase
);

  logic [PW-1:0] phIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phIdx <= '0;
    end else if (phIdx == PW'(NUM_PHASES - 1)) begin
      phIdx <= '0;
    end else begin
      phIdx <= phIdx + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_strobe
    assign qPhase[g] = (phIdx == PW'(g));
  end

endmodule

// File: rtl/seq_control.sv
module seq_control
  import seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] qPhase,
  input  logic       isBranch,
  input  logic       isCall,
  input  logic       isReturn,
  output seqStrobe_t strobe,
  output logic       execNop,
  output logic       dataRdStb,
  output logic       dataWrStb
);

  logic flowReq;
  logic flowTake;
  logic flushFlag;

  assign flowReq  = isBranch | isCall | isReturn;
  assign flowTake = qPhase[2] & ~execNop & flowReq;

  // Set by an accepted flow change, cleared once the substitute word is latched.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flushFlag <= 1'b0;
    end else if (flowTake) begin
      flushFlag <= 1'b1;
    end else if (qPhase[3]) begin
      flushFlag <= 1'b0;
    end
  end

  // Reset starts with a suppressed cycle so nothing executes while address 0 is read.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      execNop <= 1'b1;
    end else if (qPhase[3]) begin
      execNop <= flushFlag;
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.advance    = qPhase[3];
    strobe.forceNop   = flushFlag;
    strobe.pop        = flowTake & isReturn;
    strobe.push       = flowTake & isCall & ~isReturn;
    strobe.loadTarget = flowTake & ~isReturn;
  end

  assign dataRdStb = qPhase[1] & ~execNop;
  assign dataWrStb = qPhase[3] & ~execNop;

endmodule

// File: rtl/seq_ret_stack.sv
module seq_ret_stack #(
  parameter int ADDR_W = 11,
  parameter int DEPTH  = 8,
  localparam int SP_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic              pop,
  input  logic [ADDR_W-1:0] pushData,
  output logic [ADDR_W-1:0] topData
);

  logic [ADDR_W-1:0] slot [DEPTH];
  logic [SP_W-1:0]   sp;
  logic [SP_W-1:0]   spUp;
  logic [SP_W-1:0]   spDown;

  assign spUp    = (sp == SP_W'(DEPTH - 1)) ? '0 : sp + 1'b1;
  assign spDown  = (sp == '0) ? SP_W'(DEPTH - 1) : sp - 1'b1;
  assign topData = slot[spDown];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sp <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        slot[i] <= '0;
      end
    end else if (push) begin
      slot[sp] <= pushData;
      sp       <= spUp;
    end else if (pop) begin
      sp <= spDown;
    end
  end

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int              ADDR_W      = 11,
  parameter int              WORD_W      = 14,
  parameter int              STACK_DEPTH = 8,
  parameter logic [WORD_W-1:0] NOP_WORD  = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] flowTarget,
  input  logic [WORD_W-1:0] progData,
  output logic [ADDR_W-1:0] progAddr,
  output logic [WORD_W-1:0] irWord
);

  logic [ADDR_W-1:0] pcReg;     // address of the next fetch
  logic [ADDR_W-1:0] fetchAddr; // address being fetched this cycle
  logic [ADDR_W-1:0] stackTop;

  seq_ret_stack #(
    .ADDR_W(ADDR_W),
    .DEPTH (STACK_DEPTH)
  ) u_stack (
    .clk     (clk),
    .rstN    (rstN),
    .push    (strobe.push),
    .pop     (strobe.pop),
    .pushData(fetchAddr),
    .topData (stackTop)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fetchAddr <= '0;
      pcReg     <= ADDR_W'(1);
      irWord    <= NOP_WORD;
    end else if (strobe.advance) begin
      fetchAddr <= pcReg;
      pcReg     <= pcReg + 1'b1;
      irWord    <= strobe.forceNop ? NOP_WORD : progData;
    end else if (strobe.pop) begin
      pcReg <= stackTop;
    end else if (strobe.loadTarget) begin
      pcReg <= flowTarget;
    end
  end

  assign progAddr = fetchAddr;

endmodule

// File: rtl/quad_fetch_seq.sv
module quad_fetch_seq
  import seq_pkg::*;
#(
  parameter int                ADDR_W      = 11,
  parameter int                WORD_W      = 14,
  parameter int                STACK_DEPTH = 8,
  parameter logic [WORD_W-1:0] NOP_WORD    = '0
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [ADDR_W-1:0] progAddr,
  input  logic [WORD_W-1:0] progData,
  output logic [WORD_W-1:0] irWord,
  input  logic              isBranch,
  input  logic              isCall,
  input  logic              isReturn,
  input  logic [ADDR_W-1:0] flowTarget,
  output logic [3:0]        qPhase,
  output logic              dataRdStb,
  output logic              dataWrStb,
  output logic              execNop
);

  seqStrobe_t strobe;

  seq_phase_gen #(.NUM_PHASES(4)) u_phase (
    .clk   (clk),
    .rstN  (rstN),
    .qPhase(qPhase)
  );

  seq_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .qPhase   (qPhase),
    .isBranch (isBranch),
    .isCall   (isCall),
    .isReturn (isReturn),
    .strobe   (strobe),
    .execNop  (execNop),
    .dataRdStb(dataRdStb),
    .dataWrStb(dataWrStb)
  );

  seq_datapath #(
    .ADDR_W     (ADDR_W),
    .WORD_W     (WORD_W),
    .STACK_DEPTH(STACK_DEPTH),
    .NOP_WORD   (NOP_WORD)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .flowTarget(flowTarget),
    .progData  (progData),
    .progAddr  (progAddr),
    .irWord    (irWord)
  );

endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int                ADDR_W   = 11,
  parameter int                WORD_W   = 14,
  parameter logic [WORD_W-1:0] NOP_WORD = '0
) (
  input logic              clk,
  input logic              rstN,
  input logic [3:0]        qPhase,
  input logic [ADDR_W-1:0] progAddr,
  input logic [WORD_W-1:0] irWord,
  input logic              execNop,
  input logic              dataRdStb,
  input logic              dataWrStb,
  input logic              isBranch,
  input logic              isCall,
  input logic              isReturn
);

  // R1: exactly one phase strobe at a time
  a_r1_phase_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(qPhase));

  // R1: phases rotate by one position per clock
  a_r1_phase_rotate: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> qPhase == {$past(qPhase[2:0]), $past(qPhase[3])});

  // R3: the fetch address only moves at an instruction-cycle boundary
  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !qPhase[3] |=> $stable(progAddr));

  // R5: read strobe only in Q2 of an executing cycle
  a_r5_read_phase: assert property (@(posedge clk) disable iff (!rstN)
    dataRdStb |-> (qPhase[1] && !execNop));

  // R5: write strobe only in Q4 of an executing cycle
  a_r5_write_phase: assert property (@(posedge clk) disable iff (!rstN)
    dataWrStb |-> (qPhase[3] && !execNop));

  // R6: a suppressed cycle always carries the no-operation word
  a_r6_nop_word: assert property (@(posedge clk) disable iff (!rstN)
    execNop |-> irWord == NOP_WORD);

  // R6: an accepted flow request produces a suppressed next cycle
  a_r6_flush_next: assert property (@(posedge clk) disable iff (!rstN)
    (qPhase[2] && !execNop && (isBranch || isCall || isReturn)) |=> ##1 execNop);

  // R10: a suppressed cycle is followed by an executing one
  a_r10_single_nop: assert property (@(posedge clk) disable iff (!rstN)
    (qPhase[3] && execNop) |=> !execNop);

  // R10: requests during a suppressed cycle are ignored, fetch stays sequential
  a_r10_seq_after_nop: assert property (@(posedge clk) disable iff (!rstN)
    (qPhase[3] && execNop) |=> progAddr == ADDR_W'($past(progAddr) + 1'b1));

endmodule

bind quad_fetch_seq seq_checker #(
  .ADDR_W  (ADDR_W),
  .WORD_W  (WORD_W),
  .NOP_WORD(NOP_WORD)
) u_seq_checker (
  .clk      (clk),
  .rstN     (rstN),
  .qPhase   (qPhase),
  .progAddr (progAddr),
  .irWord   (irWord),
  .execNop  (execNop),
  .dataRdStb(dataRdStb),
  .dataWrStb(dataWrStb),
  .isBranch (isBranch),
  .isCall   (isCall),
  .isReturn (isReturn)
);

// File: tb/quad_fetch_seq_bench.sv
module quad_fetch_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;
  localparam int WW = 14;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] progAddr;
  logic [WW-1:0] progData;
  logic [WW-1:0] irWord;
  logic          isBranch = 1'b0;
  logic          isCall = 1'b0;
  logic          isReturn = 1'b0;
  logic [AW-1:0] flowTarget = '0;
  logic [3:0]    qPhase;
  logic          dataRdStb;
  logic          dataWrStb;
  logic          execNop;

  int            checks = 0;
  int            fails = 0;
  bit            finished = 1'b0;
  logic [AW-1:0] lastAddr = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Program memory model: every word is nonzero and encodes its address.
  assign progData = {3'b010, progAddr};

  quad_fetch_seq u_quad_fetch_seq (
    .clk       (clk),
    .rstN      (rstN),
    .progAddr  (progAddr),
    .progData  (progData),
    .irWord    (irWord),
    .isBranch  (isBranch),
    .isCall    (isCall),
    .isReturn  (isReturn),
    .flowTarget(flowTarget),
    .qPhase    (qPhase),
    .dataRdStb (dataRdStb),
    .dataWrStb (dataWrStb),
    .execNop   (execNop)
  );

  typedef struct packed {
    logic          br;
    logic          ca;
    logic          re;
    logic [AW-1:0] tgt;
    logic [AW-1:0] expAddr;
    logic          expNop;
  } vec_t;

  // One row per instruction cycle: requests driven, address and suppression expected.
  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b0, 1'b0, 11'h050, 11'h000, 1'b1}, // R2 R10: request ignored in reset cycle
    '{1'b0, 1'b0, 1'b0, 11'h000, 11'h001, 1'b0}, // R3 sequential
    '{1'b0, 1'b1, 1'b0, 11'h040, 11'h002, 1'b0}, // R7 call saves 0x002
    '{1'b1, 1'b0, 1'b0, 11'h070, 11'h040, 1'b1}, // R6 R10 branch ignored in flush cycle
    '{1'b0, 1'b0, 1'b0, 11'h000, 11'h041, 1'b0}, // R3
    '{1'b0, 1'b0, 1'b1, 11'h000, 11'h042, 1'b0}, // R8 return
    '{1'b0, 1'b0, 1'b0, 11'h000, 11'h002, 1'b1}, // R8 back at saved address
    '{1'b1, 1'b0, 1'b0, 11'h010, 11'h003, 1'b0}, // R6 branch
    '{1'b0, 1'b0, 1'b0, 11'h000, 11'h010, 1'b1}, // R6
    '{1'b1, 1'b0, 1'b0, 11'h020, 11'h011, 1'b0}, // R6 branch right after flush
    '{1'b0, 1'b0, 1'b0, 11'h000, 11'h020, 1'b1}, // R6
    '{1'b1, 1'b1, 1'b0, 11'h300, 11'h021, 1'b0}, // R9 call beats branch, saves 0x021
    '{1'b0, 1'b0, 1'b0, 11'h000, 11'h300, 1'b1}, // R9
    '{1'b1, 1'b1, 1'b1, 11'h123, 11'h301, 1'b0}, // R9 return beats both
    '{1'b0, 1'b0, 1'b0, 11'h000, 11'h021, 1'b1}, // R9 popped 0x021
    '{1'b0, 1'b0, 1'b0, 11'h000, 11'h022, 1'b0}  // R3
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Entered at a falling edge during Q1; returns at the falling edge in the next Q1.
  task automatic stepCycle(input logic br, input logic ca, input logic re,
                           input logic [AW-1:0] tgt, input logic [AW-1:0] expAddr,
                           input logic expNop, input string req);
    logic [WW-1:0] expIr;
    expIr = expNop ? '0 : {3'b010, lastAddr};
    isBranch   = br;
    isCall     = ca;
    isReturn   = re;
    flowTarget = tgt;
    chk(qPhase == 4'b0001, "R1", "phase Q1", qPhase, 4'b0001);
    chk(progAddr == expAddr, req, "progAddr", progAddr, expAddr);
    chk(execNop == expNop, req, "execNop", execNop, expNop);
    chk(irWord == expIr, "R4", "irWord", irWord, expIr);
    chk(!dataRdStb && !dataWrStb, "R5", "strobes in Q1", {dataRdStb, dataWrStb}, 0);
    @(negedge clk);
    chk(qPhase == 4'b0010, "R1", "phase Q2", qPhase, 4'b0010);
    chk(dataRdStb == !expNop, "R5", "read strobe", dataRdStb, !expNop);
    @(negedge clk);
    chk(qPhase == 4'b0100, "R1", "phase Q3", qPhase, 4'b0100);
    chk(!dataRdStb && !dataWrStb, "R5", "strobes in Q3", {dataRdStb, dataWrStb}, 0);
    @(negedge clk);
    chk(qPhase == 4'b1000, "R1", "phase Q4", qPhase, 4'b1000);
    chk(dataWrStb == !expNop, "R5", "write strobe", dataWrStb, !expNop);
    lastAddr = progAddr;
    @(negedge clk);
    isBranch = 1'b0;
    isCall   = 1'b0;
    isReturn = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    logic [AW-1:0] cur;
    logic [AW-1:0] retAddr [9];
    logic [AW-1:0] expBack;

    repeat (3) @(negedge clk);
    // R2: state held in reset
    chk(progAddr == '0, "R2", "reset progAddr", progAddr, 0);
    chk(irWord == '0, "R2", "reset irWord", irWord, 0);
    chk(execNop == 1'b1, "R2", "reset execNop", execNop, 1);
    chk(qPhase == 4'b0001, "R1", "reset phase", qPhase, 4'b0001);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      stepCycle(VECS[i].br, VECS[i].ca, VECS[i].re, VECS[i].tgt,
                VECS[i].expAddr, VECS[i].expNop, "table");
    end

    // R11: nine nested calls, then nine returns through the wrapping stack
    cur = 11'h023;
    for (int i = 0; i < 9; i++) begin
      logic [AW-1:0] tgt;
      tgt = AW'(11'h100 + i * 11'h020);
      stepCycle(1'b0, 1'b1, 1'b0, tgt, cur, 1'b0, "R11 call");
      retAddr[i] = cur;
      stepCycle(1'b0, 1'b0, 1'b0, '0, tgt, 1'b1, "R11 call target");
      cur = tgt + 1'b1;
    end
    for (int j = 0; j < 9; j++) begin
      expBack = (j < 8) ? retAddr[8 - j] : retAddr[8];
      stepCycle(1'b0, 1'b0, 1'b1, '0, cur, 1'b0, "R11 return");
      stepCycle(1'b0, 1'b0, 1'b0, '0, expBack, 1'b1, "R11 return target");
      cur = expBack + 1'b1;
    end

    // R2: reset in the middle of a cycle
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    chk(progAddr == '0, "R2", "mid-run reset progAddr", progAddr, 0);
    chk(irWord == '0, "R2", "mid-run reset irWord", irWord, 0);
    chk(execNop == 1'b1, "R2", "mid-run reset execNop", execNop, 1);
    chk(qPhase == 4'b0001, "R1", "mid-run reset phase", qPhase, 4'b0001);
    @(negedge clk);
    rstN = 1'b1;
    stepCycle(1'b0, 1'b1, 1'b0, 11'h200, 11'h000, 1'b1, "R2 R10 after reset");
    stepCycle(1'b0, 1'b0, 1'b0, '0, 11'h001, 1'b0, "R2 R3 after reset");
    stepCycle(1'b0, 1'b0, 1'b0, '0, 11'h002, 1'b0, "R3 after reset");

    finish();
  end

endmodule